// File: doc/BRIEF.md
# Inter-Thread Stride Prefetch Detector

This block sits beside the load path of a many-threaded core. It watches the stream of memory requests, in which accesses from many threads arrive interleaved. Every request carries the program counter of the load, its address and the id of the issuing thread. In data-parallel kernels a load's address is usually an affine function of the thread id. The block learns, per load, the address step between neighbouring thread ids. Once it trusts that step, it turns each further request of that load into a prefetch for another thread's line.

A table of entries, each tagged by program counter, keeps the three most recent (address, thread id) samples of its load, a learned stride and a trained flag. The table uses least-recently-used replacement. Training compares an incoming request with each stored sample of the same program counter. The address difference is divided by the thread-id difference, and a pattern is accepted only when all three pair strides agree exactly. One prefetch address at a time is offered on a valid/ready output.

Top module: `xthread_stride_pf`

## Requirements
- R1: Each request (`req_valid` high) carries a program counter, an address and a thread id. A request whose program counter is not in the table allocates an entry holding only that request as a sample, untrained, and never produces a prefetch.
- R2: A pair stride is the signed address difference (new minus stored, modulo 2^ADDR_W) divided by the signed thread-id difference (new minus stored). It is formed between the incoming request and each stored sample of the same program counter.
- R3: A pair whose thread-id difference is zero, or whose address difference is not an exact multiple of the thread-id difference, never contributes to training.
- R4: An untrained entry becomes trained when its three stored samples are present and all three pairs with the new request are usable and equal. That value becomes the stored stride. The training request itself issues no prefetch.
- R5: A request that hits a trained entry without breaking it (R7) issues a prefetch to its own address plus the stored stride, modulo 2^ADDR_W. `pf_valid` rises at the clock edge that samples the request.
- R6: Interleaved requests of different program counters train separate entries. Samples are never paired across program counters.
- R7: If the pair of a request to a trained entry with that entry's most recent sample is usable and differs from the stored stride, the entry loses its trained flag and issues no prefetch. Training then needs three new agreeing pairs.
- R8: The table holds ENTRIES (16) program counters. A miss replaces an unused entry if one exists, otherwise the least recently requested one.
- R9: At most one prefetch is offered per cycle. While `pf_valid` is high and `pf_ready` low, `pf_addr` holds and any new prefetch is discarded. When `pf_ready` is high, a new prefetch replaces the accepted one in the same cycle.
- R10: After reset the table is empty and `pf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_pc | input | PC_W | Program counter of the load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_tid | input | TID_W | Issuing thread id |
| pf_ready | input | 1 | Consumer accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
Several properties are checked on every cycle: at most one entry matches a program counter, and a held prefetch stays stable while refused. A rise of `pf_valid` must follow a request. A training or breaking event must set or clear the flag of the entry it touched. The replacement order must always name exactly one victim, and never the entry just used. Only the bench scenarios show the arithmetic: exact and inexact divisions, negative strides and repeated thread ids. They also show the interleaving of many loads, eviction of a trained load after sixteen newer ones, and the dropping of prefetches under back-pressure. For these the bench compares every output against its own table model.

// File: rtl/xtsp_pkg.sv
package xtsp_pkg;

  // Outcome of evaluating one request against the entry it hits.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,  // nothing changes except the samples
    EV_LEARN = 2'd1,  // three agreeing pairs: entry becomes trained
    EV_FIRE  = 2'd2,  // trained and consistent: issue a prefetch
    EV_BREAK = 2'd3   // trained but contradicted: drop trained flag
  } ev_e;

endpackage

// File: rtl/xtsp_eval.sv
module xtsp_eval
  import xtsp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TID_W   = 8,
  parameter int SAMPLES = 3
) (
  input  logic [ADDR_W-1:0]               new_addr,
  input  logic [TID_W-1:0]                new_tid,
  input  logic [SAMPLES-1:0][ADDR_W-1:0]  s_addr,
  input  logic [SAMPLES-1:0][TID_W-1:0]   s_tid,
  input  logic [SAMPLES-1:0]              s_v,
  input  logic                            trained,
  input  logic [ADDR_W-1:0]               stride,
  output ev_e                             ev,
  output logic [ADDR_W-1:0]               learn_stride,
  output logic [ADDR_W-1:0]               pf_target
);

  localparam int PAD = ADDR_W - TID_W - 1;

  // {usable, quotient} for one pair of samples.
  function automatic logic [ADDR_W:0] pair_calc(
    input logic [ADDR_W-1:0] a_n,
    input logic [ADDR_W-1:0] a_o,
    input logic [TID_W-1:0]  t_n,
    input logic [TID_W-1:0]  t_o
  );
    logic signed [TID_W:0]    td;
    logic signed [ADDR_W-1:0] ad;
    logic signed [ADDR_W-1:0] tde;
    logic signed [ADDR_W-1:0] q;
    logic signed [ADDR_W-1:0] r;
    td  = signed'({1'b0, t_n}) - signed'({1'b0, t_o});
    ad  = signed'(a_n - a_o);
    tde = {{PAD{td[TID_W]}}, td};
    if (td == '0) return {1'b0, {ADDR_W{1'b0}}};
    q = ad / tde;
    r = ad % tde;
    return {(r == '0), q};
  endfunction

  logic [SAMPLES-1:0]             pair_ok;
  logic [SAMPLES-1:0][ADDR_W-1:0] pair_stride;
  logic                           all_agree;

  for (genvar k = 0; k < SAMPLES; k++) begin : g_pair
    logic [ADDR_W:0] res;
    assign res            = pair_calc(new_addr, s_addr[k], new_tid, s_tid[k]);
    assign pair_ok[k]     = s_v[k] && res[ADDR_W];
    assign pair_stride[k] = res[ADDR_W-1:0];
  end

  always_comb begin
    all_agree = 1'b1;
    for (int k = 0; k < SAMPLES; k++) begin
      if (!pair_ok[k] || pair_stride[k] != pair_stride[0]) all_agree = 1'b0;
    end
  end

  always_comb begin
    if (trained) begin
      ev = (pair_ok[0] && pair_stride[0] != stride) ? EV_BREAK : EV_FIRE;
    end else begin
      ev = all_agree ? EV_LEARN : EV_NONE;
    end
  end

  assign learn_stride = pair_stride[0];
  assign pf_target    = new_addr + stride;

endmodule

// File: rtl/xtsp_lru.sv
module xtsp_lru #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] victim_idx
);

  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age;
  logic [N-1:0]         max_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_max
    assign max_hit[i] = (age[i] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (max_hit[i]) victim_idx = IW'(i);
    end
  end

  // R8
  lru_victim_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(max_hit));

  // R8
  lru_not_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> victim_idx != $past(touch_idx));

endmodule

// File: rtl/xtsp_pf_slot.sv
module xtsp_pf_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] fire_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  logic dropped;
  assign dropped = fire && pf_valid && !pf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (fire && (!pf_valid || pf_ready)) begin
      pf_valid <= 1'b1;
      pf_addr  <= fire_addr;
    end else if (pf_valid && pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R9
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  // R9
  pf_drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> $stable(pf_addr));

endmodule

// File: rtl/xthread_stride_pf.sv
module xthread_stride_pf
  import xtsp_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 32,
  parameter int TID_W   = 8,
  parameter int ENTRIES = 16,
  parameter int SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TID_W-1:0]  req_tid,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int IW = $clog2(ENTRIES);

  // Table state
  logic [ENTRIES-1:0]                          ent_v;
  logic [ENTRIES-1:0][PC_W-1:0]                ent_pc;
  logic [ENTRIES-1:0]                          ent_trained;
  logic [ENTRIES-1:0][ADDR_W-1:0]              ent_stride;
  logic [ENTRIES-1:0][SAMPLES-1:0][ADDR_W-1:0] samp_addr;
  logic [ENTRIES-1:0][SAMPLES-1:0][TID_W-1:0]  samp_tid;
  logic [ENTRIES-1:0][SAMPLES-1:0]             samp_v;

  // Named events
  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic               miss;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      victim_idx;
  logic [IW-1:0]      tgt_idx;
  ev_e                ev;
  logic [ADDR_W-1:0]  learn_stride;
  logic [ADDR_W-1:0]  pf_target;
  logic               fire;
  logic               learn_evt;
  logic               break_evt;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = ent_v[g] && (ent_pc[g] == req_pc);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit     = req_valid && (|hit_vec);
  assign miss    = req_valid && !(|hit_vec);
  assign tgt_idx = hit ? hit_idx : victim_idx;

  xtsp_eval #(
    .ADDR_W (ADDR_W),
    .TID_W  (TID_W),
    .SAMPLES(SAMPLES)
  ) u_eval (
    .new_addr    (req_addr),
    .new_tid     (req_tid),
    .s_addr      (samp_addr[hit_idx]),
    .s_tid       (samp_tid[hit_idx]),
    .s_v         (samp_v[hit_idx]),
    .trained     (ent_trained[hit_idx]),
    .stride      (ent_stride[hit_idx]),
    .ev          (ev),
    .learn_stride(learn_stride),
    .pf_target   (pf_target)
  );

  assign fire      = hit && (ev == EV_FIRE);
  assign learn_evt = hit && (ev == EV_LEARN);
  assign break_evt = hit && (ev == EV_BREAK);

  xtsp_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (req_valid),
    .touch_idx (tgt_idx),
    .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v       <= '0;
      ent_pc      <= '0;
      ent_trained <= '0;
      ent_stride  <= '0;
      samp_addr   <= '0;
      samp_tid    <= '0;
      samp_v      <= '0;
    end else if (miss) begin
      ent_v[tgt_idx]        <= 1'b1;
      ent_pc[tgt_idx]       <= req_pc;
      ent_trained[tgt_idx]  <= 1'b0;
      ent_stride[tgt_idx]   <= '0;
      samp_addr[tgt_idx][0] <= req_addr;
      samp_tid[tgt_idx][0]  <= req_tid;
      samp_v[tgt_idx]       <= SAMPLES'(1);
    end else if (hit) begin
      for (int k = SAMPLES - 1; k > 0; k--) begin
        samp_addr[tgt_idx][k] <= samp_addr[tgt_idx][k-1];
        samp_tid[tgt_idx][k]  <= samp_tid[tgt_idx][k-1];
      end
      samp_addr[tgt_idx][0] <= req_addr;
      samp_tid[tgt_idx][0]  <= req_tid;
      samp_v[tgt_idx]       <= {samp_v[tgt_idx][SAMPLES-2:0], 1'b1};
      if (learn_evt) begin
        ent_trained[tgt_idx] <= 1'b1;
        ent_stride[tgt_idx]  <= learn_stride;
      end else if (break_evt) begin
        ent_trained[tgt_idx] <= 1'b0;
      end
    end
  end

  xtsp_pf_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .fire_addr(pf_target),
    .pf_ready (pf_ready),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr)
  );

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit_vec));

  // R5
  pf_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(req_valid));

  // R4
  learn_sets_trained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    learn_evt |=> ent_trained[$past(hit_idx)]);

  // R7
  break_clears_trained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_evt |=> !ent_trained[$past(hit_idx)]);

  // R1
  miss_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (ent_v[$past(victim_idx)] && !ent_trained[$past(victim_idx)]
              && ent_pc[$past(victim_idx)] == $past(req_pc)));

endmodule

// File: tb/xthread_stride_pf_test.sv
module xthread_stride_pf_test;

  localparam int NE = 16;
  localparam int NS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_pc;
  logic [31:0] req_addr;
  logic [7:0]  req_tid;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;

  always #2.5 clk = ~clk;

  xthread_stride_pf uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_pc   (req_pc),
    .req_addr (req_addr),
    .req_tid  (req_tid),
    .pf_ready (pf_ready),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R10";

  // Bench model of the table
  bit          m_v   [NE];
  logic [15:0] m_pc  [NE];
  bit          m_tr  [NE];
  int          m_str [NE];
  logic [31:0] m_a   [NE][NS];
  logic [7:0]  m_t   [NE][NS];
  int          m_cnt [NE];
  longint      m_stamp[NE];
  longint      now = 0;
  bit          exp_v = 0;
  logic [31:0] exp_a = '0;

  function automatic void model_reset();
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_tr[i] = 0; m_cnt[i] = 0; m_stamp[i] = 0;
    end
    exp_v = 0;
  endfunction

  function automatic void model_req(bit v, logic [15:0] pc, logic [31:0] a,
                                    logic [7:0] t, bit rdy);
    bit fire = 0;
    logic [31:0] tgt = '0;
    int h = -1;
    if (v) begin
      now++;
      for (int i = 0; i < NE; i++) if (m_v[i] && m_pc[i] == pc) h = i;
      if (h >= 0) begin
        bit ok[NS];
        int q[NS];
        bit agree = 1;
        for (int k = 0; k < NS; k++) begin
          int ad = int'(a - m_a[h][k]);
          int td = int'(t) - int'(m_t[h][k]);
          ok[k] = 0; q[k] = 0;
          if (k < m_cnt[h] && td != 0) begin
            q[k] = ad / td;
            ok[k] = (q[k] * td == ad);
          end
          if (!ok[k] || q[k] != q[0]) agree = 0;
        end
        if (m_tr[h]) begin
          if (ok[0] && q[0] != m_str[h]) m_tr[h] = 0;
          else begin fire = 1; tgt = a + 32'(m_str[h]); end
        end else if (agree) begin
          m_tr[h] = 1; m_str[h] = q[0];
        end
        for (int k = NS - 1; k > 0; k--) begin
          m_a[h][k] = m_a[h][k-1]; m_t[h][k] = m_t[h][k-1];
        end
        m_a[h][0] = a; m_t[h][0] = t;
        if (m_cnt[h] < NS) m_cnt[h]++;
      end else begin
        h = -1;
        for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) h = i;
        if (h < 0) begin
          h = 0;
          for (int i = 1; i < NE; i++) if (m_stamp[i] < m_stamp[h]) h = i;
        end
        m_v[h] = 1; m_pc[h] = pc; m_tr[h] = 0; m_str[h] = 0;
        m_a[h][0] = a; m_t[h][0] = t; m_cnt[h] = 1;
      end
      m_stamp[h] = now;
    end
    if (fire && (!exp_v || rdy)) begin exp_v = 1; exp_a = tgt; end
    else if (exp_v && rdy) exp_v = 0;
  endfunction

  task automatic compare();
    checks++;
    if (pf_valid !== exp_v) begin
      fails++;
      $display("FAIL %s pf_valid actual=%0b expected=%0b", cur_req, pf_valid, exp_v);
    end
    if (exp_v) begin
      checks++;
      if (pf_addr !== exp_a) begin
        fails++;
        $display("FAIL %s pf_addr actual=%h expected=%h", cur_req, pf_addr, exp_a);
      end
    end
  endtask

  task automatic step(bit v, logic [15:0] pc, logic [31:0] a, logic [7:0] t, bit rdy);
    @(negedge clk);
    compare();
    req_valid = v; req_pc = pc; req_addr = a; req_tid = t; pf_ready = rdy;
    model_req(v, pc, a, t, rdy);
  endtask

  // Request for an affine pattern: addr = base + stride * tid
  task automatic areq(logic [15:0] pc, int base, int stride, int tid, bit rdy = 1);
    step(1'b1, pc, 32'(base + stride * tid), 8'(tid), rdy);
  endtask

  initial begin
    req_valid = 0; req_pc = '0; req_addr = '0; req_tid = '0; pf_ready = 1;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R10: reset state
    cur_req = "R10";
    checks++;
    if (pf_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 pf_valid after reset actual=%0b expected=0", pf_valid);
    end
    step(0, '0, '0, '0, 1);

    // R1 / R4 / R5: thread ids 1,3,10,5 then further threads
    cur_req = "R4";
    areq(16'h001a, 32'h1000, 100, 1);
    cur_req = "R1";
    areq(16'h001a, 32'h1000, 100, 3);
    areq(16'h001a, 32'h1000, 100, 10);
    cur_req = "R4";
    areq(16'h001a, 32'h1000, 100, 5);
    cur_req = "R5";
    areq(16'h001a, 32'h1000, 100, 7);
    areq(16'h001a, 32'h1000, 100, 2);
    step(0, '0, '0, '0, 1);

    // R2: negative strides and decreasing thread ids, swept
    cur_req = "R2";
    for (int s = -96; s <= 96; s += 24) begin
      logic [15:0] pc = 16'(16'h0200 + s + 96);
      for (int j = 0; j < 6; j++) areq(pc, 32'h0004_0000, s, 40 - 5 * j);
    end

    // R3: repeated thread ids and inexact divisions never train
    cur_req = "R3";
    for (int j = 0; j < 6; j++) step(1, 16'h0300, 32'(32'h5000 + 8 * j), 8'd9, 1);
    step(1, 16'h0301, 32'h6000, 8'd0, 1);
    step(1, 16'h0301, 32'h6097, 8'd2, 1);
    step(1, 16'h0301, 32'h6131, 8'd4, 1);
    step(1, 16'h0301, 32'h6200, 8'd6, 1);
    step(1, 16'h0301, 32'h6300, 8'd8, 1);
    step(0, '0, '0, '0, 1);

    // R6: four loads interleaved round-robin
    cur_req = "R6";
    for (int j = 0; j < 8; j++) begin
      for (int p = 0; p < 4; p++) begin
        areq(16'(16'h0400 + p), 32'(32'h10000 * (p + 1)), 4 << p, (j * 7 + p * 3) % 64);
      end
    end

    // R7: contradict a trained load, then retrain it
    cur_req = "R7";
    for (int j = 0; j < 5; j++) areq(16'h0500, 32'h8000, 16, j);
    areq(16'h0500, 32'h8000, 48, 9);
    areq(16'h0500, 32'h8000, 16, 11);
    for (int j = 12; j < 17; j++) areq(16'h0500, 32'h8000, 16, j);

    // R8: trained load survives 15 newer, evicted by 16 newer
    cur_req = "R8";
    for (int j = 0; j < 4; j++) areq(16'h0600, 32'h9000, 8, j);
    for (int p = 0; p < 15; p++) areq(16'(16'h0700 + p), 32'h100, 4, 1);
    areq(16'h0600, 32'h9000, 8, 5);
    for (int p = 0; p < 16; p++) areq(16'(16'h0800 + p), 32'h100, 4, 1);
    areq(16'h0600, 32'h9000, 8, 6);
    areq(16'h0600, 32'h9000, 8, 7);

    // R9: back-pressure holds the offer and drops new ones
    cur_req = "R9";
    for (int j = 0; j < 4; j++) areq(16'h0900, 32'hA000, 32, j);
    for (int j = 4; j < 10; j++) areq(16'h0900, 32'hA000, 32, j, 0);
    step(0, '0, '0, '0, 0);
    areq(16'h0900, 32'hA000, 32, 20, 1);
    areq(16'h0900, 32'hA000, 32, 21, 1);
    step(0, '0, '0, '0, 0);
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);

    // R5 / R9 / R8: mixed sweep over 20 loads with noise and back-pressure
    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      int p     = int'($urandom_range(19, 0));
      int s     = ((p * 37) % 51) - 25;
      int tid   = int'($urandom_range(255, 0));
      int noise = ($urandom_range(15, 0) == 0) ? 1 : 0;
      bit v     = ($urandom_range(7, 0) != 0);
      bit rdy   = ($urandom_range(3, 0) != 0);
      step(v, 16'(16'h0A00 + p), 32'(32'h0010_0000 * (p + 1) + s * tid + noise),
           8'(tid), rdy);
    end
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);
    @(negedge clk);
    compare();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule